// File: doc/BRIEF.md
# Receive-to-Transmit FIFO Loopback Mover

This block sits between a processor-side clock domain and a slave FIFO device that exposes four byte-wide endpoint ports behind one shared address select. Two of those ports receive data from a host and two send data back. Whenever the device signals that new data has arrived, the mover picks a receive port that holds data. It copies that port byte by byte into its fixed partner transmit port and stops once the receive port reports empty.

Each byte costs six clocks: select setup, read strobe, select hold, select setup, write strobe, select hold. The select stays steady around every strobe. A write waits for as long as the destination port is full. Separately, a one-cycle commit request for either transmit port makes the mover send a commit pulse to that port, so that a packet shorter than the configured length goes out. Commits are served only while no pass is running.

Top module: `lbm_loopback_mover`

## Requirements
- R1: The port select `sel_o` is encoded 2'b00 = receive port A, 2'b01 = receive port B, 2'b10 = transmit port A, 2'b11 = transmit port B. Bytes read from receive A are written only to transmit A, and bytes from receive B only to transmit B, in the order they were read.
- R2: A byte move is a read strobe on the source, then a write strobe on the destination that carries exactly the byte on `rd_data_i` at the clock edge ending the read strobe. No two of `rd_o`, `wr_o` and `commit_o` are ever high in the same cycle.
- R3: Once a pass has started, the mover keeps moving bytes from its source until the source's empty flag (bit 0 = receive A, bit 1 = receive B) is seen high before a read. It never strobes a read while that flag was high.
- R4: A pass starts only after a one-cycle `data_avail_i` pulse, and only if a receive port holds data. A pulse while both are empty causes no strobe. Data with no pulse causes no strobe. A pulse that arrives during a pass is remembered and starts a new pass when the current one ends.
- R5: When both receive ports hold data at the start of a pass, the port not served by the previous pass is chosen. After reset, receive A counts as the next to be chosen.
- R6: No write strobe is issued to a transmit port while its full flag in `dst_full_i` (bit 0 = transmit A, bit 1 = transmit B) was high in the cycle before. The pending byte is written once the flag drops.
- R7: `sel_o` holds the same value in the cycle before, during and after every read, write or commit strobe.
- R8: A pulse on `commit_req_i` (bit 0 = transmit A, bit 1 = transmit B) is remembered and produces exactly one single-cycle `commit_o` with `sel_o` on that transmit port. When both are waiting, transmit A goes first.
- R9: A commit is issued only when no pass is in progress. A request raised during a pass is held until the pass has written its last byte.
- R10: After reset, `rd_o`, `wr_o` and `commit_o` are low and `sel_o` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| data_avail_i | input | 1 | One-cycle pulse: new receive data may be present |
| src_empty_i | input | 2 | Empty flags of receive ports A and B |
| dst_full_i | input | 2 | Full flags of transmit ports A and B |
| commit_req_i | input | 2 | One-cycle short-packet commit requests for transmit A and B |
| rd_data_i | input | DATA_W | Byte from the selected receive port |
| sel_o | output | 2 | Port select to the FIFO device |
| rd_o | output | 1 | Read strobe |
| wr_o | output | 1 | Write strobe |
| wr_data_o | output | DATA_W | Byte written to the selected transmit port |
| commit_o | output | 1 | Packet commit strobe |

## Verification
The bench drives the mover with a single receive port loaded, the other port loaded, and both loaded at once. These cases separate the fixed pairing from the alternating choice of source. A refill of one port between passes shows that the choice follows the last served port and not only which port is non-empty. Event pulses with empty ports, loaded ports with no pulse, and a pulse during a running pass show that the pass trigger is gated and remembered. A stalled full flag, a commit raised mid-pass and two simultaneous commits check the write hold-off, the deferral of commits and their ordering.

// File: rtl/lbm_pkg.sv
package lbm_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SRC_SU,
        ST_RD,
        ST_RD_HLD,
        ST_DST_SU,
        ST_WR,
        ST_WR_HLD,
        ST_CM_SU,
        ST_CM,
        ST_CM_HLD
    } lbm_state_e;

    typedef struct packed {
        lbm_state_e state;
        logic       src;      // 0 = receive A, 1 = receive B
        logic       last;     // source of the previous pass
        logic       ev_pend;  // data-available event not yet served
        logic       cidx;     // transmit port of the commit in flight
    } lbm_ctl_t;
endpackage

// File: rtl/lbm_src_arb.sv
module lbm_src_arb (
    input  logic [1:0] src_empty_i,
    input  logic       last_i,
    output logic       avail_o,
    output logic       pick_o
);
    always_comb begin
        avail_o = ~&src_empty_i;
        if (src_empty_i == 2'b00) begin
            pick_o = ~last_i;
        end else begin
            pick_o = src_empty_i[0];
        end
    end
endmodule

// File: rtl/lbm_commit_track.sv
module lbm_commit_track (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] req_i,
    input  logic       take_i,
    output logic       pend_any_o,
    output logic       pick_o
);
    logic [1:0] pend_d, pend_q;
    logic [1:0] clr;

    always_comb begin
        pick_o     = ~pend_q[0];
        pend_any_o = |pend_q;
        clr        = 2'b00;
        if (take_i) begin
            clr[pick_o] = 1'b1;
        end
        pend_d = (pend_q & ~clr) | req_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 2'b00;
        end else begin
            pend_q <= pend_d;
        end
    end

    a_r8_take_pending: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |-> pend_any_o);
endmodule

// File: rtl/lbm_loopback_mover.sv
module lbm_loopback_mover #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_avail_i,
    input  logic [1:0]        src_empty_i,
    input  logic [1:0]        dst_full_i,
    input  logic [1:0]        commit_req_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic [1:0]        sel_o,
    output logic              rd_o,
    output logic              wr_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              commit_o
);
    import lbm_pkg::*;

    localparam logic SIDE_RX = 1'b0;
    localparam logic SIDE_TX = 1'b1;

    lbm_ctl_t          ctl_d, ctl_q;
    logic [DATA_W-1:0] data_d, data_q;
    logic              arb_avail, arb_pick;
    logic              cm_any, cm_pick, cm_take;
    logic              ev_now;

    lbm_src_arb u_arb (
        .src_empty_i (src_empty_i),
        .last_i      (ctl_q.last),
        .avail_o     (arb_avail),
        .pick_o      (arb_pick)
    );

    lbm_commit_track u_cm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (commit_req_i),
        .take_i     (cm_take),
        .pend_any_o (cm_any),
        .pick_o     (cm_pick)
    );

    always_comb begin
        ctl_d         = ctl_q;
        data_d        = data_q;
        cm_take       = 1'b0;
        ev_now        = ctl_q.ev_pend | data_avail_i;
        ctl_d.ev_pend = ev_now;
        case (ctl_q.state)
            ST_IDLE: begin
                if (cm_any) begin
                    cm_take     = 1'b1;
                    ctl_d.cidx  = cm_pick;
                    ctl_d.state = ST_CM_SU;
                end else if (ev_now) begin
                    ctl_d.ev_pend = 1'b0;
                    if (arb_avail) begin
                        ctl_d.src   = arb_pick;
                        ctl_d.last  = arb_pick;
                        ctl_d.state = ST_SRC_SU;
                    end
                end
            end
            ST_SRC_SU: ctl_d.state = src_empty_i[ctl_q.src] ? ST_IDLE : ST_RD;
            ST_RD: begin
                data_d      = rd_data_i;
                ctl_d.state = ST_RD_HLD;
            end
            ST_RD_HLD: ctl_d.state = ST_DST_SU;
            ST_DST_SU: if (!dst_full_i[ctl_q.src]) ctl_d.state = ST_WR;
            ST_WR:     ctl_d.state = ST_WR_HLD;
            ST_WR_HLD: ctl_d.state = ST_SRC_SU;
            ST_CM_SU:  ctl_d.state = ST_CM;
            ST_CM:     ctl_d.state = ST_CM_HLD;
            ST_CM_HLD: ctl_d.state = ST_IDLE;
            default:   ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_IDLE, src: 1'b0, last: 1'b1, ev_pend: 1'b0, cidx: 1'b0};
            data_q <= '0;
        end else begin
            ctl_q  <= ctl_d;
            data_q <= data_d;
        end
    end

    always_comb begin
        case (ctl_q.state)
            ST_SRC_SU, ST_RD, ST_RD_HLD:  sel_o = {SIDE_RX, ctl_q.src};
            ST_DST_SU, ST_WR, ST_WR_HLD:  sel_o = {SIDE_TX, ctl_q.src};
            ST_CM_SU, ST_CM, ST_CM_HLD:   sel_o = {SIDE_TX, ctl_q.cidx};
            default:                      sel_o = 2'b00;
        endcase
    end

    assign rd_o      = (ctl_q.state == ST_RD);
    assign wr_o      = (ctl_q.state == ST_WR);
    assign commit_o  = (ctl_q.state == ST_CM);
    assign wr_data_o = data_q;

    logic empty_sel, full_sel;
    assign empty_sel = src_empty_i[sel_o[0]];
    assign full_sel  = dst_full_i[sel_o[0]];

    a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({rd_o, wr_o, commit_o}) <= 1);
    a_r1_rd_rx_port: assert property (@(posedge clk) disable iff (!rst_n)
        rd_o |-> !sel_o[1]);
    a_r1_wr_tx_port: assert property (@(posedge clk) disable iff (!rst_n)
        wr_o |-> sel_o[1]);
    a_r3_rd_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
        rd_o |-> !$past(empty_sel));
    a_r6_no_wr_full: assert property (@(posedge clk) disable iff (!rst_n)
        wr_o |-> !$past(full_sel));
    a_r7_sel_before: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_o || wr_o || commit_o) |-> $stable(sel_o));
    a_r7_sel_after: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_o || wr_o || commit_o) |=> $stable(sel_o));
    a_r8_commit_single: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> !commit_o);
    a_r9_commit_tx_port: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> sel_o[1]);
endmodule

// File: tb/lbm_loopback_mover_tb_top.sv
module lbm_loopback_mover_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       data_avail_i = 1'b0;
    logic [1:0] src_empty_i = 2'b11;
    logic [1:0] full_force = 2'b00;
    logic [1:0] dst_full_i;
    logic [1:0] commit_req_i = 2'b00;
    logic [7:0] rd_data_i = 8'h00;
    logic [1:0] sel_o;
    logic       rd_o, wr_o, commit_o;
    logic [7:0] wr_data_o;

    int checks = 0;
    int errors = 0;
    int n_strobes = 0;
    logic [7:0] sq0[$], sq1[$];
    int wlog[$];
    int clog[$];
    int cwr[$];
    bit       pend_valid = 0;
    bit       pend_src = 0;
    int       pend_byte = 0;
    bit       prev_strobe = 0;
    logic [1:0] prev_sel = 2'b00;

    always #2 clk = ~clk;
    assign dst_full_i = full_force;

    lbm_loopback_mover #(.DATA_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .data_avail_i(data_avail_i),
        .src_empty_i(src_empty_i), .dst_full_i(dst_full_i),
        .commit_req_i(commit_req_i), .rd_data_i(rd_data_i),
        .sel_o(sel_o), .rd_o(rd_o), .wr_o(wr_o),
        .wr_data_o(wr_data_o), .commit_o(commit_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // device model and cycle-by-cycle reference comparison
    always @(negedge clk) begin
        bit strobe;
        int v;
        if (rst_n) begin
            strobe = rd_o | wr_o | commit_o;
            if (prev_strobe) chk(sel_o == prev_sel, "R7 select after strobe", sel_o, prev_sel);
            if (strobe) chk(sel_o == prev_sel, "R7 select before strobe", sel_o, prev_sel);
            if (strobe) n_strobes++;
            chk(int'(rd_o) + int'(wr_o) + int'(commit_o) <= 1, "R2 one strobe per cycle",
                int'(rd_o) + int'(wr_o) + int'(commit_o), 1);
            v = 0;
            if (rd_o) begin
                chk(sel_o[1] == 1'b0, "R1 read on receive port", sel_o, 0);
                if (sel_o[0] == 1'b0 && sq0.size() > 0) v = sq0.pop_front();
                else if (sel_o[0] == 1'b1 && sq1.size() > 0) v = sq1.pop_front();
                else chk(0, "R3 read from empty port", sel_o, 0);
                pend_valid = 1;
                pend_src   = sel_o[0];
                pend_byte  = v;
            end
            rd_data_i = 8'(v);
            if (wr_o) begin
                chk(pend_valid, "R2 write follows a read", 0, 1);
                chk(sel_o == {1'b1, pend_src}, "R1 destination pairing", sel_o, {1'b1, pend_src});
                chk(int'(wr_data_o) == pend_byte, "R2 written byte", wr_data_o, pend_byte);
                chk(!full_force[sel_o[0]], "R6 write while full", 1, 0);
                wlog.push_back(int'(sel_o) * 256 + int'(wr_data_o));
                pend_valid = 0;
            end
            if (commit_o) begin
                chk(!pend_valid, "R9 commit inside byte move", 1, 0);
                chk(sel_o[1] == 1'b1, "R8 commit on transmit port", sel_o, 2);
                clog.push_back(int'(sel_o));
                cwr.push_back(wlog.size());
            end
            prev_strobe = strobe;
            prev_sel    = sel_o;
        end
        src_empty_i = {sq1.size() == 0, sq0.size() == 0};
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_avail();
        data_avail_i = 1'b1;
        run(1);
        data_avail_i = 1'b0;
    endtask

    task automatic expect_log(input string tag, input int e[$]);
        chk(wlog.size() == e.size(), {tag, " byte count"}, wlog.size(), e.size());
        foreach (e[i]) begin
            if (i < wlog.size()) chk(wlog[i] == e[i], tag, wlog[i], e[i]);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int e[$];
        int s0;
        run(3);
        // R10 reset state
        chk({rd_o, wr_o, commit_o} == 3'b000, "R10 strobes low in reset", {rd_o, wr_o, commit_o}, 0);
        chk(sel_o == 2'b00, "R10 select in reset", sel_o, 0);
        rst_n = 1'b1;
        run(2);
        chk({rd_o, wr_o, commit_o} == 3'b000, "R10 strobes low after reset", {rd_o, wr_o, commit_o}, 0);

        // R1 R3: receive A only
        wlog.delete();
        sq0 = '{8'd11, 8'd12, 8'd13};
        run(2); pulse_avail(); run(40);
        e = '{512 + 11, 512 + 12, 512 + 13};
        expect_log("R1 R3 receive A drained to transmit A", e);
        chk(sq0.size() == 0, "R3 receive A empty", sq0.size(), 0);

        // R1: receive B only
        wlog.delete();
        sq1 = '{8'd21, 8'd22};
        run(2); pulse_avail(); run(30);
        e = '{768 + 21, 768 + 22};
        expect_log("R1 receive B to transmit B", e);

        // R5: both loaded, alternation across passes
        wlog.delete();
        sq0 = '{8'd31, 8'd32};
        sq1 = '{8'd41};
        run(2); pulse_avail(); run(30);
        sq0.push_back(8'd33);
        run(2); pulse_avail(); run(30);
        e = '{512 + 31, 512 + 32, 768 + 41};
        expect_log("R5 alternating source choice", e);
        chk(sq0.size() == 1, "R4 no pass without event", sq0.size(), 1);
        pulse_avail(); run(20);
        e.push_back(512 + 33);
        expect_log("R5 remaining byte after event", e);

        // R4: event during pass is remembered
        wlog.delete();
        sq1 = '{8'd51, 8'd52};
        run(2); pulse_avail(); run(3);
        sq0.push_back(8'd61);
        run(1); pulse_avail(); run(50);
        e = '{768 + 51, 768 + 52, 512 + 61};
        expect_log("R4 event during pass starts next pass", e);

        // R4: events with nothing, data with no event
        s0 = n_strobes;
        pulse_avail(); run(20);
        chk(n_strobes == s0, "R4 event with empty ports", n_strobes - s0, 0);
        sq0 = '{8'd71};
        run(30);
        chk(n_strobes == s0, "R4 data without event", n_strobes - s0, 0);
        wlog.delete();
        pulse_avail(); run(20);
        e = '{512 + 71};
        expect_log("R4 pass after late event", e);

        // R6: destination full holds writes
        wlog.delete();
        full_force = 2'b01;
        sq0 = '{8'd81, 8'd82};
        run(2); pulse_avail(); run(40);
        chk(wlog.size() == 0, "R6 no write while full", wlog.size(), 0);
        full_force = 2'b00;
        run(30);
        e = '{512 + 81, 512 + 82};
        expect_log("R6 writes resume after full drops", e);

        // R9: commit raised mid-pass waits for pass end
        wlog.delete(); clog.delete(); cwr.delete();
        sq0 = '{8'd91, 8'd92, 8'd93, 8'd94};
        run(2); pulse_avail(); run(8);
        commit_req_i = 2'b01; run(1); commit_req_i = 2'b00;
        run(60);
        chk(clog.size() == 1, "R8 one commit pulse", clog.size(), 1);
        if (clog.size() > 0) begin
            chk(clog[0] == 2, "R8 commit on transmit A", clog[0], 2);
            chk(cwr[0] == 4, "R9 commit after last byte", cwr[0], 4);
        end

        // R8: simultaneous commits, transmit A first
        clog.delete();
        commit_req_i = 2'b11; run(1); commit_req_i = 2'b00;
        run(20);
        chk(clog.size() == 2, "R8 two commit pulses", clog.size(), 2);
        if (clog.size() == 2) begin
            chk(clog[0] == 2, "R8 first commit transmit A", clog[0], 2);
            chk(clog[1] == 3, "R8 second commit transmit B", clog[1], 3);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule